// File: doc/BRIEF.md
# Monte Carlo Quarter-Circle Sampling Core

This core estimates pi by throwing pseudo-random points into the unit square and counting how many land inside the quarter circle of radius one. The host loads a first and a last trial index together with one seed for each of the two coordinate generators, then pulses `start`. An internal index counter walks the range and launches one trial per clock. Each trial takes a fresh fixed-point pair (x, y) in [0,1), squares both, adds them and marks a hit when the sum stays below one. A saturating accumulator totals the hits while a second counter totals the finished trials.

Once the last trial has left the pipeline the core raises `done` for one cycle. Both totals then stay fixed until the next `start`. The host forms the estimate as 4 · hits / trials. Several cores can run in parallel as long as each one gets its own seeds.

Top module: `mcPiCore`

## Requirements
- R1: A run contains one trial for each index from `rangeFirst` to `rangeLast` inclusive, both unsigned. When `rangeLast` < `rangeFirst` the run contains no trials. `trialCount` rises by one for each finished trial and ends equal to that number. A range that ends at the largest index value ends the run without wrapping.
- R2: Each coordinate comes from a combined generator with three 32-bit components. On every trial each component steps as `b = ((s << Q) ^ s) >> S; s = ((s & M) << K) ^ b`, with (Q,S,K,M) = (13,19,12,0xFFFFFFFE), (2,25,4,0xFFFFFFF8) and (3,11,17,0xFFFFFFF0). The coordinate is bits [31:16] of the XOR of the three stepped components. Component c is seeded from bits [32c+31:32c] of its seed port: `seedX` drives x and `seedY` drives y.
- R3: A trial is a hit exactly when x² + y² < 2³², with x and y read as 16-bit fractions and the squares kept at full 32-bit width. Each hit adds one to `hitCount`.
- R4: `hitCount` saturates at 2^ACC_W − 1 and does not wrap.
- R5: Trials are launched on consecutive clocks. If `start` is sampled at edge E0 and the run holds N ≥ 1 trials, trial k has been counted after edge E0+k+3 and `done` is high in the cycle after edge E0+N+4. With N = 0, `done` is high in the cycle after edge E0+1.
- R6: `done` is a single-cycle pulse. After it, `hitCount` and `trialCount` stay unchanged until the next `start`.
- R7: While reset is held, and after it until the first `start`, `done`, `hitCount` and `trialCount` are zero.
- R8: A `start` that arrives during a run drops every trial still in flight and begins the new run from zero counts.
- R9: When the seed bits a component keeps under its mask M are all zero, the lowest bit of M is set in that component's seed. Zero seeds therefore still produce a valid sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Loads range and seeds, clears totals, begins a run |
| rangeFirst | input | CNT_W | First trial index |
| rangeLast | input | CNT_W | Last trial index (inclusive) |
| seedX | input | 96 | Three 32-bit component seeds for the x generator |
| seedY | input | 96 | Three 32-bit component seeds for the y generator |
| done | output | 1 | One-cycle pulse once the run has drained |
| hitCount | output | ACC_W | Saturating number of hits |
| trialCount | output | CNT_W+1 | Number of finished trials |

## Verification
The hardest state to reach from the ports is accumulator saturation, because it would take around 2^48 trials at the default width. The bench therefore builds the core with a 7-bit accumulator so that a 300-trial run crosses the limit while a 100-trial run stays under it. A second hard case is a restart that lands while trials are still inside the three pipeline stages. The bench places `start` twenty cycles into a long run and checks that no stale hit reaches the new totals. A reference model runs the generator recurrence independently and compares all three outputs on every clock.

// File: rtl/mcPiPkg.sv
package mcPiPkg;
  localparam int TAUS_W = 32;
  localparam int TAUS_N = 3;
  localparam int SEED_W = TAUS_W * TAUS_N;

  typedef struct packed {
    logic load;   // capture range and seeds, flush pipeline, clear totals
    logic issue;  // launch one trial this cycle
  } mcStrobe_t;

  function automatic int tausQ(input int c);
    return (c == 0) ? 13 : (c == 1) ? 2 : 3;
  endfunction
  function automatic int tausS(input int c);
    return (c == 0) ? 19 : (c == 1) ? 25 : 11;
  endfunction
  function automatic int tausK(input int c);
    return (c == 0) ? 12 : (c == 1) ? 4 : 17;
  endfunction
  function automatic int tausLow(input int c);
    return (c == 0) ? 1 : (c == 1) ? 3 : 4;
  endfunction
endpackage

// File: rtl/mcTausGen.sv
module mcTausGen
  import mcPiPkg::*;
#(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              advance,
  input  logic [SEED_W-1:0] seed,
  output logic [FRAC_W-1:0] sample
);
  logic [TAUS_N-1:0][TAUS_W-1:0] nextParts;
  logic [TAUS_W-1:0] mix;

  for (genvar c = 0; c < TAUS_N; c++) begin : g_comp
    localparam int Q = tausQ(c);
    localparam int S = tausS(c);
    localparam int K = tausK(c);
    localparam int LOW = tausLow(c);
    localparam logic [TAUS_W-1:0] MASK = ~((TAUS_W'(1) << LOW) - TAUS_W'(1));

    logic [TAUS_W-1:0] st, sd, sdFix, nx;

    assign sd    = seed[c*TAUS_W +: TAUS_W];
    // R9: a seed with no bits under the mask gets the lowest masked bit set
    assign sdFix = ((sd & MASK) == '0) ? (sd | (TAUS_W'(1) << LOW)) : sd;
    assign nx    = ((st & MASK) << K) ^ (((st << Q) ^ st) >> S);
    assign nextParts[c] = nx;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        st <= '1;
      else if (load)    st <= sdFix;
      else if (advance) st <= nx;
    end

    a_r9_legal_state: assert property (@(posedge clk) disable iff (!rstN)
      load |=> ((st & MASK) != '0));
  end

  always_comb begin
    mix = '0;
    for (int c = 0; c < TAUS_N; c++) mix ^= nextParts[c];
  end

  assign sample = mix[TAUS_W-1 -: FRAC_W];
endmodule

// File: rtl/mcPiDatapath.sv
module mcPiDatapath
  import mcPiPkg::*;
#(
  parameter int FRAC_W = 16,
  parameter int ACC_W  = 48,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mcStrobe_t         strobe,
  input  logic [SEED_W-1:0] seedX,
  input  logic [SEED_W-1:0] seedY,
  output logic              pipeBusy,
  output logic [ACC_W-1:0]  hitCount,
  output logic [CNT_W:0]    trialCount
);
  localparam int SQ_W = 2 * FRAC_W;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [1:0][SEED_W-1:0] seeds;
  logic [1:0][FRAC_W-1:0] draws;
  assign seeds = {seedY, seedX};

  for (genvar g = 0; g < 2; g++) begin : g_axis
    mcTausGen #(.FRAC_W(FRAC_W)) u_gen (
      .clk(clk), .rstN(rstN), .load(strobe.load), .advance(strobe.issue),
      .seed(seeds[g]), .sample(draws[g])
    );
  end

  // stage 1: sampled coordinates
  logic v1, v2, v3;
  logic [FRAC_W-1:0] xR, yR;
  // stage 2: squares; stage 3: compare result
  logic [SQ_W-1:0] sqX, sqY;
  logic [SQ_W:0]   sumW;
  logic            hitR;

  assign sumW = {1'b0, sqX} + {1'b0, sqY};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      xR <= '0; yR <= '0; sqX <= '0; sqY <= '0; hitR <= 1'b0;
    end else begin
      v1 <= strobe.issue & ~strobe.load;
      v2 <= v1 & ~strobe.load;
      v3 <= v2 & ~strobe.load;
      if (strobe.issue) begin
        xR <= draws[0];
        yR <= draws[1];
      end
      sqX  <= xR * xR;
      sqY  <= yR * yR;
      hitR <= ~sumW[SQ_W];   // carry into bit SQ_W means sum >= one
    end
  end

  assign pipeBusy = v1 | v2 | v3;

  // reduce: saturating hit accumulation and trial tally
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitCount   <= '0;
      trialCount <= '0;
    end else if (strobe.load) begin
      hitCount   <= '0;
      trialCount <= '0;
    end else if (v3) begin
      trialCount <= trialCount + 1'b1;
      if (hitR && hitCount != ACC_MAX) hitCount <= hitCount + 1'b1;
    end
  end

  a_r4_sat_hold: assert property (@(posedge clk) disable iff (!rstN)
    (hitCount == ACC_MAX && !strobe.load) |=> hitCount == ACC_MAX);

  a_r3_hits_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (ACC_W + CNT_W + 1)'(hitCount) <= (ACC_W + CNT_W + 1)'(trialCount));

  a_r1_tally_step: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> (trialCount == $past(trialCount) ||
                      trialCount == $past(trialCount) + 1'b1));

  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !pipeBusy) |=> ($stable(trialCount) && $stable(hitCount)));
endmodule

// File: rtl/mcPiCtrl.sv
module mcPiCtrl
  import mcPiPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] rangeFirst,
  input  logic [CNT_W-1:0] rangeLast,
  input  logic             pipeBusy,
  output mcStrobe_t        strobe,
  output logic             done
);
  logic             running, pending;
  logic [CNT_W-1:0] idx, lastR;
  logic             drained;

  assign strobe.load  = start;
  assign strobe.issue = running & ~start;
  assign drained      = pending & ~running & ~pipeBusy & ~start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0; pending <= 1'b0; done <= 1'b0;
      idx <= '0; lastR <= '0;
    end else begin
      done <= drained;
      if (start) begin
        idx     <= rangeFirst;
        lastR   <= rangeLast;
        running <= (rangeFirst <= rangeLast);
        pending <= 1'b1;
      end else begin
        if (strobe.issue) begin
          idx <= idx + 1'b1;
          if (idx == lastR) running <= 1'b0;
        end
        if (drained) pending <= 1'b0;
      end
    end
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r5_done_after_drain: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!running && !pipeBusy));
endmodule

// File: rtl/mcPiCore.sv
module mcPiCore
  import mcPiPkg::*;
#(
  parameter int FRAC_W = 16,
  parameter int ACC_W  = 48,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  rangeFirst,
  input  logic [CNT_W-1:0]  rangeLast,
  input  logic [SEED_W-1:0] seedX,
  input  logic [SEED_W-1:0] seedY,
  output logic              done,
  output logic [ACC_W-1:0]  hitCount,
  output logic [CNT_W:0]    trialCount
);
  mcStrobe_t strobe;
  logic      pipeBusy;

  mcPiCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .rangeFirst(rangeFirst), .rangeLast(rangeLast),
    .pipeBusy(pipeBusy), .strobe(strobe), .done(done)
  );

  mcPiDatapath #(.FRAC_W(FRAC_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .seedX(seedX), .seedY(seedY), .pipeBusy(pipeBusy),
    .hitCount(hitCount), .trialCount(trialCount)
  );
endmodule

// File: tb/mcPiCore_tb.sv
`timescale 1ns/1ps
module mcPiCore_tb;
  localparam int FRAC_W = 16;
  localparam int ACC_W  = 7;
  localparam int CNT_W  = 32;
  localparam longint ACC_MAX = (64'd1 << ACC_W) - 1;
  localparam int MAXN = 4096;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rstN, start;
  logic [CNT_W-1:0] rangeFirst, rangeLast;
  logic [95:0]      seedX, seedY;
  logic             done;
  logic [ACC_W-1:0] hitCount;
  logic [CNT_W:0]   trialCount;

  mcPiCore #(.FRAC_W(FRAC_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .rangeFirst(rangeFirst), .rangeLast(rangeLast),
    .seedX(seedX), .seedY(seedY),
    .done(done), .hitCount(hitCount), .trialCount(trialCount)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // ---------------- reference model ----------------
  bit     active = 0;
  longint nTr = 0;
  longint since = 0;
  int     pre [0:MAXN];

  function automatic logic [31:0] fixSeed(input logic [31:0] s, input int low);
    logic [31:0] m;
    m = ~((32'd1 << low) - 32'd1);
    return ((s & m) == 32'd0) ? (s | (32'd1 << low)) : s;   // R9
  endfunction

  // R2: one step of the three-component generator, returns the 16-bit draw
  function automatic logic [15:0] draw(inout logic [31:0] a, inout logic [31:0] b,
                                       inout logic [31:0] c);
    logic [31:0] t;
    t = ((a << 13) ^ a) >> 19; a = ((a & 32'hFFFFFFFE) << 12) ^ t;
    t = ((b << 2)  ^ b) >> 25; b = ((b & 32'hFFFFFFF8) << 4)  ^ t;
    t = ((c << 3)  ^ c) >> 11; c = ((c & 32'hFFFFFFF0) << 17) ^ t;
    t = a ^ b ^ c;
    return t[31:16];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      active = 0;
    end else if (start) begin
      logic [31:0] xa, xb, xc, ya, yb, yc;
      logic [15:0] x, y;
      longint sq;
      active = 1;
      since  = 0;
      nTr = (rangeLast >= rangeFirst) ? (longint'(rangeLast) - longint'(rangeFirst) + 1) : 0;
      if (nTr > MAXN) nTr = MAXN;
      xa = fixSeed(seedX[31:0], 1); xb = fixSeed(seedX[63:32], 3); xc = fixSeed(seedX[95:64], 4);
      ya = fixSeed(seedY[31:0], 1); yb = fixSeed(seedY[63:32], 3); yc = fixSeed(seedY[95:64], 4);
      pre[0] = 0;
      for (int k = 1; k <= nTr; k++) begin
        x = draw(xa, xb, xc);
        y = draw(ya, yb, yc);
        sq = longint'(x) * longint'(x) + longint'(y) * longint'(y);
        pre[k] = pre[k-1] + ((sq < (64'd1 << 32)) ? 1 : 0);   // R3
      end
    end else if (active) begin
      since++;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycles, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    longint t, eh;
    bit ed;
    if (!active) begin
      t = 0; eh = 0; ed = 0;   // R7: reset and pre-run state
    end else begin
      t = since - 3;
      if (t < 0) t = 0;
      if (t > nTr) t = nTr;
      eh = pre[t];
      if (eh > ACC_MAX) eh = ACC_MAX;                      // R4
      ed = (nTr == 0) ? (since == 1) : (since == nTr + 4); // R5, R6
    end
    check("R1 trialCount", longint'(trialCount), t);
    check("R3/R4 hitCount", longint'(hitCount), eh);
    check("R5/R6 done", longint'(done), longint'(ed));
  end

  task automatic runRange(input logic [CNT_W-1:0] f, input logic [CNT_W-1:0] l,
                          input logic [95:0] sx, input logic [95:0] sy, input int hold);
    @(posedge clk); #1;
    rangeFirst = f; rangeLast = l; seedX = sx; seedY = sy; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (hold) @(posedge clk);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; rangeFirst = '0; rangeLast = '0; seedX = '0; seedY = '0;
    fork
      begin
        repeat (4) @(posedge clk);   // R7: outputs held at zero in reset
        #1 rstN = 1'b1;
        repeat (5) @(posedge clk);   // R7: still zero before any start
        // R1, R2, R3, R5: 100-trial run below saturation
        runRange(32'd10, 32'd109, 96'h1234_5678_9ABC_DEF0_0F1E_2D3C,
                 96'hCAFE_F00D_1357_9BDF_2468_ACE0, 112);
        // R6: totals held while idle
        repeat (10) @(posedge clk);
        // R1, R5: single-trial run
        runRange(32'd7, 32'd7, 96'h0000_1111_2222_3333_4444_5555,
                 96'h6666_7777_8888_9999_AAAA_BBBB, 10);
        // R1, R5: empty range
        runRange(32'd9, 32'd8, 96'h1, 96'h2, 6);
        // R9: all-zero seeds are corrected
        runRange(32'd1, 32'd40, 96'h0, 96'h0, 50);
        // R8: restart while trials are in flight
        runRange(32'd0, 32'd199, 96'hDEAD_BEEF_0BAD_F00D_FEED_FACE,
                 96'h0123_4567_89AB_CDEF_7654_3210, 20);
        runRange(32'd5, 32'd54, 96'hA5A5_5A5A_C3C3_3C3C_9696_6969,
                 96'h1F2E_3D4C_5B6A_7988_0102_0304, 60);
        // R4: saturation of the accumulator
        runRange(32'd0, 32'd299, 96'h2222_4444_6666_8888_AAAA_CCCC,
                 96'h1357_2468_9BDF_ACE0_1111_EEEE, 310);
        // R1: range ending at the largest index, no wrap
        runRange(32'hFFFF_FFF0, 32'hFFFF_FFFF, 96'h0F0F_F0F0_1234_4321_ABCD_DCBA,
                 96'h7777_1111_3333_5555_9999_BBBB, 30);
      end
      begin
        wait (cycles >= 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cycles);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule